// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two levels of translation tables that are held in memory. A request carries the virtual address. At the moment the request is taken, the block also captures a table base address and an outer-table length from its configuration inputs, so a context switch only has to change those two inputs.

The walker makes at most two reads through a memory read port that allows one read in flight at a time. The first read fetches the outer-table entry, which gives the base of an inner table. The second read fetches the inner entry, which gives the frame number. The frame number is joined to the untouched page offset to form the physical address.

A walk can fail in three ways, and each is reported with its own cause code:
- the outer index is out of range for the table length;
- the outer entry is not valid;
- the inner entry is not valid.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, and after it is released with no request pending, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The virtual address is split into an outer index of bits 31:22, an inner index of bits 21:14 and a page offset of bits 13:0.
- R3: The first read goes to the captured table base plus four times the outer index, computed modulo 2^32.
- R4: In every table entry, bit 0 is the valid flag. A valid outer entry gives the inner table base as its bits 31:10 followed by ten zero bits, so bits 9:1 are ignored. The second read goes to that inner base plus four times the inner index.
- R5: When the outer index is equal to or greater than `cfg_table_len`, the response is a fault with cause 1 and no memory read is issued.
- R6: When the outer entry has bit 0 clear, the response is a fault with cause 2 after exactly one memory read. `rsp_fault` is 1 exactly when `rsp_cause` is not 0.
- R7: When the inner entry has bit 0 clear, the response is a fault with cause 3 after exactly two memory reads.
- R8: A successful walk responds with `rsp_fault` 0, cause 0, and `rsp_pa` equal to bits 31:14 of the inner entry followed by the 14-bit page offset. Bits 13:1 of the inner entry are ignored.
- R9: At most one memory read is outstanding. A read request that is not accepted keeps its address stable. The next read is not raised until the data of the previous one has returned.
- R10: `rsp_valid` is a one-cycle pulse and is followed by `req_ready` 1. While a walk is busy, `req_ready` is 0 and a raised `req_valid` has no effect on the result of that walk.
- R11: The table base and table length are captured when a request is accepted. Changing them during a walk does not affect that walk's read addresses or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| cfg_table_base | input | 32 | Byte address of the outer table |
| cfg_table_len | input | 11 | Number of outer entries in range |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 length, 2 outer invalid, 3 inner invalid |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry data return strobe |
| mem_rsp_data | input | 32 | Returned table entry |

## Verification
The hardest situation to reach from the ports is one where read backpressure, a late memory reply and a configuration change all fall inside a single walk. Under those conditions a walker that re-reads the base register, or that raises a second read before the first reply, would go wrong. The bench reaches this situation with a memory model whose reply latency and accept stalling are set per test vector. It also changes the base and length inputs, and raises a stray request, while a walk is in flight. The model's table contents are computed from the index values, with junk in the ignored entry bits and with invalid entries at known indices. This lets every fault cause, the length boundary and the masking rules be predicted from the virtual address alone.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W        = 32;
    localparam int OUTER_W     = 10;
    localparam int INNER_W     = 8;
    localparam int OFFSET_W    = 14;
    localparam int PTE_W       = 32;
    localparam int PA_W        = 32;
    localparam int ENTRY_BYTES = 4;

    localparam int ENTRY_SHIFT   = $clog2(ENTRY_BYTES);
    localparam int FRAME_W       = PA_W - OFFSET_W;
    localparam int LEN_W         = OUTER_W + 1;
    localparam int INNER_ALIGN_W = INNER_W + ENTRY_SHIFT;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_OUTER,
        ST_RD_INNER,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'd0,
        CAUSE_LENGTH    = 2'd1,
        CAUSE_OUTER_INV = 2'd2,
        CAUSE_INNER_INV = 2'd3
    } fault_cause_e;

    typedef struct packed {
        logic [OUTER_W-1:0]  outer;
        logic [INNER_W-1:0]  inner;
        logic [OFFSET_W-1:0] offset;
    } va_fields_t;

    typedef struct packed {
        logic               valid;
        logic [PA_W-1:0]    next_base;
        logic [FRAME_W-1:0] frame;
    } pte_view_t;

    function automatic logic [PA_W-1:0] scale_index(input logic [OUTER_W-1:0] idx);
        return {{(PA_W-OUTER_W-ENTRY_SHIFT){1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_idx_unit.sv
module ptw_idx_unit
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic [LEN_W-1:0] table_len,
    output va_fields_t       fields,
    output logic             in_range
);
    always_comb begin
        fields   = va_fields_t'(va);
        in_range = ({1'b0, fields.outer} < table_len);
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic            use_inner,
    input  logic [PA_W-1:0] outer_base,
    input  logic [PA_W-1:0] inner_base,
    input  va_fields_t      fields,
    output logic [PA_W-1:0] entry_addr
);
    logic [PA_W-1:0] outer_off;
    logic [PA_W-1:0] inner_off;

    always_comb begin
        outer_off = scale_index(fields.outer);
        inner_off = scale_index({{(OUTER_W-INNER_W){1'b0}}, fields.inner});
        entry_addr = use_inner ? (inner_base + inner_off) : (outer_base + outer_off);
    end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    output pte_view_t        view
);
    logic unused_rsvd;

    always_comb begin
        view.valid     = pte[0];
        view.next_base = {pte[PTE_W-1:INNER_ALIGN_W], {INNER_ALIGN_W{1'b0}}};
        view.frame     = pte[PTE_W-1:OFFSET_W];
        unused_rsvd    = ^pte[INNER_ALIGN_W-1:1];
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [PA_W-1:0]   cfg_table_base,
    input  logic [LEN_W-1:0]  cfg_table_len,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data
);
    walk_state_e     state_q;
    fault_cause_e    cause_q;
    va_fields_t      va_q;
    logic [PA_W-1:0] base_q;
    logic [PA_W-1:0] inner_base_q;
    logic [PA_W-1:0] pa_q;
    logic            issued_q;

    va_fields_t      req_fields;
    logic            req_in_range;
    pte_view_t       entry;
    logic            accept;
    logic            rd_fire;
    logic            entry_back;
    logic            reading;

    ptw_idx_unit u_idx (
        .va        (req_va),
        .table_len (cfg_table_len),
        .fields    (req_fields),
        .in_range  (req_in_range)
    );

    ptw_addr_gen u_addr (
        .use_inner  (state_q == ST_RD_INNER),
        .outer_base (base_q),
        .inner_base (inner_base_q),
        .fields     (va_q),
        .entry_addr (mem_req_addr)
    );

    ptw_pte_decode u_dec (
        .pte  (mem_rsp_data),
        .view (entry)
    );

    always_comb begin
        reading       = (state_q == ST_RD_OUTER) || (state_q == ST_RD_INNER);
        req_ready     = (state_q == ST_IDLE);
        accept        = req_valid && req_ready;
        mem_req_valid = reading && !issued_q;
        rd_fire       = mem_req_valid && mem_req_ready;
        entry_back    = reading && issued_q && mem_rsp_valid;
        rsp_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
        rsp_fault     = (state_q == ST_FAULT);
        rsp_cause     = cause_q;
        rsp_pa        = (state_q == ST_DONE) ? pa_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            cause_q      <= CAUSE_NONE;
            va_q         <= '0;
            base_q       <= '0;
            inner_base_q <= '0;
            pa_q         <= '0;
            issued_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        va_q     <= req_fields;
                        base_q   <= cfg_table_base;
                        issued_q <= 1'b0;
                        if (req_in_range) begin
                            cause_q <= CAUSE_NONE;
                            state_q <= ST_RD_OUTER;
                        end else begin
                            cause_q <= CAUSE_LENGTH;
                            state_q <= ST_FAULT;
                        end
                    end
                end
                ST_RD_OUTER: begin
                    if (entry_back) begin
                        issued_q <= 1'b0;
                        if (entry.valid) begin
                            inner_base_q <= entry.next_base;
                            state_q      <= ST_RD_INNER;
                        end else begin
                            cause_q <= CAUSE_OUTER_INV;
                            state_q <= ST_FAULT;
                        end
                    end else if (rd_fire) begin
                        issued_q <= 1'b1;
                    end
                end
                ST_RD_INNER: begin
                    if (entry_back) begin
                        issued_q <= 1'b0;
                        if (entry.valid) begin
                            pa_q    <= {entry.frame, va_q.offset};
                            state_q <= ST_DONE;
                        end else begin
                            cause_q <= CAUSE_INNER_INV;
                            state_q <= ST_FAULT;
                        end
                    end else if (rd_fire) begin
                        issued_q <= 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    AST_LEN_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_in_range) |=>
            (rsp_valid && rsp_fault && rsp_cause == CAUSE_LENGTH && !mem_req_valid)) // R5
        else $error("length fault path");

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))) // R9
        else $error("read request dropped or changed");

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid) // R9
        else $error("second read raised before reply");

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready)) // R10
        else $error("response not a single pulse");

    AST_PA_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[OFFSET_W-1:0] == va_q.offset)) // R8
        else $error("offset not carried through");

    AST_CAUSE_MATCH: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_cause != CAUSE_NONE))) // R6
        else $error("fault flag and cause disagree");

endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

    localparam logic [31:0] TBASE  = 32'h0000_8000;
    localparam logic [31:0] TBASE2 = 32'h0000_4000;
    localparam logic [31:0] IBASE  = 32'h0010_0000;
    localparam int NVEC = 9;

    // fields: outer(10) inner(8) offset(14) len(11) latency(2) stall(1)
    localparam logic [45:0] VEC [NVEC] = '{
        {10'd0,    8'd0,   14'h1234, 11'd1024, 2'd1, 1'b0},
        {10'd1022, 8'd255, 14'h3FFF, 11'd1024, 2'd2, 1'b1},
        {10'd1023, 8'd0,   14'h0001, 11'd1024, 2'd1, 1'b0},
        {10'd3,    8'd5,   14'h0000, 11'd1024, 2'd3, 1'b1},
        {10'd4,    8'd6,   14'h2222, 11'd1024, 2'd1, 1'b1},
        {10'd10,   8'd1,   14'h0ABC, 11'd10,   2'd1, 1'b0},
        {10'd9,    8'd1,   14'h0ABC, 11'd10,   2'd2, 1'b0},
        {10'd0,    8'd2,   14'h0005, 11'd0,    2'd1, 1'b0},
        {10'd7,    8'd13,  14'h1111, 11'd1024, 2'd3, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] cfg_table_base = TBASE;
    logic [10:0] cfg_table_len = 11'd1024;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_pa;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    bit          stall_en = 1'b0;
    logic [1:0]  lat = 2'd1;
    logic [1:0]  rsp_cnt = 2'd0;
    logic [31:0] rsp_data_q = '0;
    logic [31:0] addr_log [64];
    int          nlog = 0;

    always #4 clk = ~clk;

    pt_walker i_pt_walker (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_va         (req_va),
        .cfg_table_base (cfg_table_base),
        .cfg_table_len  (cfg_table_len),
        .rsp_valid      (rsp_valid),
        .rsp_fault      (rsp_fault),
        .rsp_cause      (rsp_cause),
        .rsp_pa         (rsp_pa),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data)
    );

    function automatic logic [17:0] frame_of(input logic [9:0] i, input logic [7:0] j);
        return {i, j} ^ 18'h2A5C3;
    endfunction

    function automatic bit outer_ok(input logic [9:0] i);
        return (i % 5) != 3;
    endfunction

    function automatic bit inner_ok(input logic [7:0] j);
        return (j % 7) != 6;
    endfunction

    // table contents, with junk in the bits the walker must ignore
    function automatic logic [31:0] model(input logic [31:0] a);
        logic [9:0] i;
        logic [7:0] j;
        if (a >= TBASE && a < TBASE + 32'd4096) begin
            i = 10'((a - TBASE) >> 2);
            return (IBASE + {12'd0, i, 10'd0}) | {22'd0, 9'h155, outer_ok(i)};
        end else if (a >= IBASE) begin
            i = 10'((a - IBASE) >> 10);
            j = a[9:2];
            return {frame_of(i, j), 13'h0AAA, inner_ok(j)};
        end
        return 32'h0000_03FE;
    endfunction

    assign mem_rsp_valid = (rsp_cnt == 2'd1);
    assign mem_rsp_data  = mem_rsp_valid ? rsp_data_q : 32'hDEAD_BEEE;

    always @(posedge clk) begin
        if (rsp_cnt != 2'd0) rsp_cnt <= rsp_cnt - 2'd1;
        if (mem_req_valid && mem_req_ready) begin
            rsp_cnt    <= lat;
            rsp_data_q <= model(mem_req_addr);
            if (nlog < 64) addr_log[nlog] <= mem_req_addr;
            nlog <= nlog + 1;
        end
    end

    always @(negedge clk) mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic walk(input logic [9:0] i, input logic [7:0] j, input logic [13:0] off,
                        input logic [10:0] len, input bit disturb);
        int n0;
        int waited;
        bit busy_ready;
        int reads;
        logic [1:0]  exp_cause;
        int          exp_reads;
        logic [31:0] exp_pa;
        @(negedge clk);
        cfg_table_base = TBASE;
        cfg_table_len  = len;
        req_va         = {i, j, off};
        req_valid      = 1'b1;
        n0             = nlog;
        @(negedge clk);
        req_valid  = 1'b0;
        waited     = 0;
        busy_ready = 1'b0;
        while (!rsp_valid && waited < 60) begin
            if (req_ready) busy_ready = 1'b1;
            if (disturb) begin
                cfg_table_base = TBASE2;
                cfg_table_len  = 11'd0;
                req_valid      = 1'b1;
                req_va         = 32'hFFFF_FFFF;
            end
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        if (i >= len)          begin exp_cause = 2'd1; exp_reads = 0; end
        else if (!outer_ok(i)) begin exp_cause = 2'd2; exp_reads = 1; end
        else if (!inner_ok(j)) begin exp_cause = 2'd3; exp_reads = 2; end
        else                   begin exp_cause = 2'd0; exp_reads = 2; end
        exp_pa = (exp_cause == 2'd0) ? {frame_of(i, j), off} : 32'd0;
        check(rsp_valid == 1'b1, "R10 response arrives", {31'd0, rsp_valid}, 32'd1);
        check(rsp_cause == exp_cause, exp_cause == 2'd1 ? "R5 cause" :
              exp_cause == 2'd2 ? "R6 cause" : exp_cause == 2'd3 ? "R7 cause" : "R8 cause",
              {30'd0, rsp_cause}, {30'd0, exp_cause});
        check(rsp_fault == (exp_cause != 2'd0), "R6 fault flag", {31'd0, rsp_fault},
              {31'd0, exp_cause != 2'd0});
        check(rsp_pa == exp_pa, "R8 physical address", rsp_pa, exp_pa);
        check(!busy_ready, "R10 busy not ready", {31'd0, busy_ready}, 32'd0);
        @(negedge clk);
        reads = nlog - n0;
        check(reads == exp_reads, "R9 read count", reads, exp_reads);
        if (exp_reads >= 1)
            check(addr_log[n0] == TBASE + {20'd0, i, 2'b00}, "R3 outer address",
                  addr_log[n0], TBASE + {20'd0, i, 2'b00});
        if (exp_reads == 2)
            check(addr_log[n0+1] == IBASE + {12'd0, i, 10'd0} + {22'd0, j, 2'b00},
                  "R4 inner address", addr_log[n0+1],
                  IBASE + {12'd0, i, 10'd0} + {22'd0, j, 2'b00});
        check(!rsp_valid && req_ready, "R10 single pulse then ready",
              {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req_valid, "R1 in reset",
              {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req_valid, "R1 after reset",
              {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);

        // R2 R3 R4 R5 R6 R7 R8 R9: table of vectors
        for (int k = 0; k < NVEC; k++) begin
            lat      = VEC[k][2:1];
            stall_en = VEC[k][0];
            walk(VEC[k][45:36], VEC[k][35:28], VEC[k][27:14], VEC[k][13:3], 1'b0);
        end

        // R11: base and length change during a walk, plus stray request (R10)
        lat      = 2'd3;
        stall_en = 1'b1;
        walk(10'd12, 8'd20, 14'h0777, 11'd1024, 1'b1);
        stall_en = 1'b0;
        lat      = 2'd1;
        walk(10'd2, 8'd3, 14'h0042, 11'd3, 1'b1);

        // R2: high offset bits and top index edges
        walk(10'd1, 8'd128, 14'h2001, 11'd2, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule